// File: doc/BRIEF.md
# Dual-Issue Hazard Controller for a SIMD Issue Stage

This block makes the issue decisions for an in-order SIMD pipeline that can start up to two instructions per cycle. In every cycle it is shown the two oldest pending instructions, called slot 0 (older) and slot 1 (younger). For each slot it gets a valid bit, the class of functional unit the instruction needs, a latency class, a destination register index and two source register indexes. It answers with a grant for each slot. A granted instruction has issued in that cycle, and the pending queue upstream advances by the number of grants.

The block keeps two kinds of hazard state. The first is a busy down-counter for each functional unit. It records how many more cycles a multi-cycle operation holds that unit. The second is a pending counter for each architectural register. It covers the execute and write-back stages of the instruction that will write that register.

A multi-cycle operation lets a second instruction issue next to it only on its first cycle and on its last cycle. On every cycle in between, slot 1 is held back. Instruction fetch, decode, the arithmetic datapath and the register file storage are outside this block.

Top module: `dual_issue_ctl`

## Requirements
- R1: Reset is synchronous. While reset is high neither grant is asserted. After reset every unit is free and no register is pending, even if an operation had issued just before reset.
- R2: The unit code is 0 for arithmetic, 1 for load/store, 2 for scalar, and 3 is reserved. An instruction with unit code 3 is never granted. A latency bit of 1 selects a multiply (MUL_CYCLES = 4 cycles) and 0 selects an add (ADD_CYCLES = 2 cycles).
- R3: An operation of latency L granted in cycle t holds its unit for cycles t to t+L-1. A new instruction for that unit may be granted from cycle t+L-1 (the last cycle) onward. The two slots are never granted to the same unit in one cycle.
- R4: In a cycle where any unit is in an intermediate cycle (t+1 to t+L-2) of its operation, slot 1 is not granted. Pairing is allowed on an operation's first cycle and its last cycle, so an add never closes the pairing window.
- R5: When nothing is busy or pending, slot 1 is granted alongside slot 0 exactly when both are valid, both unit codes are legal, and the two unit codes differ.
- R6: Slot 1 is not granted if it reads or writes slot 0's destination, or if it writes a register that slot 0 reads.
- R7: The destination of an instruction of latency L granted in cycle t is pending from cycle t+1 through cycle t+L+2 (two write-back stages). An instruction whose sources or destination match a pending register is not granted before cycle t+L+3, and it is granted in that cycle.
- R8: Issue is in order. Slot 1 is never granted in a cycle where slot 0 is not granted, including when slot 0 is invalid or blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_unit | input | 2 | Slot 0 unit code |
| s0_mul | input | 1 | Slot 0 latency class (1 = multiply) |
| s0_dst | input | 4 | Slot 0 destination register |
| s0_src0 | input | 4 | Slot 0 first source register |
| s0_src1 | input | 4 | Slot 0 second source register |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_unit | input | 2 | Slot 1 unit code |
| s1_mul | input | 1 | Slot 1 latency class (1 = multiply) |
| s1_dst | input | 4 | Slot 1 destination register |
| s1_src0 | input | 4 | Slot 1 first source register |
| s1_src1 | input | 4 | Slot 1 second source register |
| grant0 | output | 1 | Slot 0 issues this cycle |
| grant1 | output | 1 | Slot 1 issues this cycle |

## Verification
The assertions check four things on every cycle. Reset empties the unit and register state. The busy and pending counters stay within their bounds. The cycle after a multiply issues grants neither a second arithmetic instruction nor slot 1. The cycle after slot 0 issues does not let slot 0 read the register just written.

Some properties are about exact cycles and can only be shown by the bench's scenarios. These are the cycle in which a held unit accepts its next operation, the cycle in which a pending register frees a dependent instruction for each latency class and operand position, and the point where the pairing window reopens on the last cycle. The bench also shows that the pairing decision is right across every combination of unit and latency in the two slots.

// File: rtl/dic_pkg.sv
package dic_pkg;
    typedef enum logic [1:0] {
        UC_ARITH  = 2'd0,
        UC_LDST   = 2'd1,
        UC_SCALAR = 2'd2,
        UC_RSVD   = 2'd3
    } unit_e;

    localparam int NUM_UNITS = 3;
    localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/dic_unit_tracker.sv
// Busy down-counter per functional unit: value = further cycles held.
module dic_unit_tracker
    import dic_pkg::*;
#(
    parameter int MUL_CYCLES = 4,
    parameter int ADD_CYCLES = 2,
    parameter int CNT_W      = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_SLOTS-1:0]             iss_valid,
    input  logic [NUM_SLOTS-1:0][1:0]        iss_unit,
    input  logic [NUM_SLOTS-1:0]             iss_mul,
    output logic [NUM_UNITS-1:0]             unit_free,
    output logic                             mid_busy
);
    localparam logic [CNT_W-1:0] MUL_LOAD = CNT_W'(MUL_CYCLES - 1);
    localparam logic [CNT_W-1:0] ADD_LOAD = CNT_W'(ADD_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        logic [NUM_UNITS-1:0][CNT_W-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic [NUM_UNITS-1:0] mid_vec;

    always_comb begin
        st_d = st_q;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (st_q.cnt[u] != '0) begin
                st_d.cnt[u] = st_q.cnt[u] - ONE;
            end
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (iss_valid[s] && (iss_unit[s] == 2'(u))) begin
                    st_d.cnt[u] = iss_mul[s] ? MUL_LOAD : ADD_LOAD;
                end
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign unit_free[u] = (st_q.cnt[u] <= ONE);
        assign mid_vec[u]   = (st_q.cnt[u] > ONE);

        AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
            st_q.cnt[u] <= MUL_LOAD); // R3
    end

    assign mid_busy = |mid_vec;

    AST_RESET_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q == '0)); // R1
endmodule

// File: rtl/dic_scoreboard.sv
// Pending counter per register, covering execute plus write-back stages.
module dic_scoreboard
    import dic_pkg::*;
#(
    parameter int NUM_REGS   = 16,
    parameter int REG_W      = 4,
    parameter int PEND_W     = 3,
    parameter int MUL_CYCLES = 4,
    parameter int ADD_CYCLES = 2,
    parameter int WB_STAGES  = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_SLOTS-1:0]              set_valid,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0]   set_dst,
    input  logic [NUM_SLOTS-1:0]              set_mul,
    output logic [NUM_REGS-1:0]               pend_vec
);
    localparam logic [PEND_W-1:0] MUL_HOLD = PEND_W'(MUL_CYCLES + WB_STAGES);
    localparam logic [PEND_W-1:0] ADD_HOLD = PEND_W'(ADD_CYCLES + WB_STAGES);
    localparam logic [PEND_W-1:0] ONE      = PEND_W'(1);

    typedef struct packed {
        logic [NUM_REGS-1:0][PEND_W-1:0] pend;
    } sb_t;

    sb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (st_q.pend[r] != '0) begin
                st_d.pend[r] = st_q.pend[r] - ONE;
            end
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (set_valid[s] && (set_dst[s] == REG_W'(r))) begin
                    st_d.pend[r] = set_mul[s] ? MUL_HOLD : ADD_HOLD;
                end
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign pend_vec[r] = (st_q.pend[r] != '0);

        AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
            st_q.pend[r] <= MUL_HOLD); // R7
    end

    AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        $past(set_valid[0]) |-> pend_vec[$past(set_dst[0])]); // R7

    AST_RESET_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_vec == '0)); // R1
endmodule

// File: rtl/dic_slot_hazard.sv
// Per-slot readiness: legal unit, unit accepting, no pending operand.
module dic_slot_hazard
    import dic_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4
) (
    input  logic                  valid,
    input  logic [1:0]            unit,
    input  logic [REG_W-1:0]      dst,
    input  logic [REG_W-1:0]      src0,
    input  logic [REG_W-1:0]      src1,
    input  logic [NUM_REGS-1:0]   pend_vec,
    input  logic [NUM_UNITS-1:0]  unit_free,
    output logic                  ready
);
    logic unit_ok;
    logic regs_ok;

    always_comb begin
        case (unit_e'(unit))
            UC_ARITH:  unit_ok = unit_free[0];
            UC_LDST:   unit_ok = unit_free[1];
            UC_SCALAR: unit_ok = unit_free[2];
            default:   unit_ok = 1'b0;
        endcase
        regs_ok = !pend_vec[src0] && !pend_vec[src1] && !pend_vec[dst];
        ready   = valid && unit_ok && regs_ok;
    end
endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
    import dic_pkg::*;
#(
    parameter int NUM_REGS   = 16,
    parameter int MUL_CYCLES = 4,
    parameter int ADD_CYCLES = 2,
    parameter int WB_STAGES  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         s0_valid,
    input  logic [1:0]                   s0_unit,
    input  logic                         s0_mul,
    input  logic [$clog2(NUM_REGS)-1:0]  s0_dst,
    input  logic [$clog2(NUM_REGS)-1:0]  s0_src0,
    input  logic [$clog2(NUM_REGS)-1:0]  s0_src1,
    input  logic                         s1_valid,
    input  logic [1:0]                   s1_unit,
    input  logic                         s1_mul,
    input  logic [$clog2(NUM_REGS)-1:0]  s1_dst,
    input  logic [$clog2(NUM_REGS)-1:0]  s1_src0,
    input  logic [$clog2(NUM_REGS)-1:0]  s1_src1,
    output logic                         grant0,
    output logic                         grant1
);
    localparam int REG_W  = $clog2(NUM_REGS);
    localparam int CNT_W  = $clog2(MUL_CYCLES + 1);
    localparam int PEND_W = $clog2(MUL_CYCLES + WB_STAGES + 1);

    logic [NUM_SLOTS-1:0]            sl_valid;
    logic [NUM_SLOTS-1:0][1:0]       sl_unit;
    logic [NUM_SLOTS-1:0]            sl_mul;
    logic [NUM_SLOTS-1:0][REG_W-1:0] sl_dst;
    logic [NUM_SLOTS-1:0][REG_W-1:0] sl_src0;
    logic [NUM_SLOTS-1:0][REG_W-1:0] sl_src1;
    logic [NUM_SLOTS-1:0]            sl_ready;
    logic [NUM_SLOTS-1:0]            iss;
    logic [NUM_UNITS-1:0]            unit_free;
    logic [NUM_REGS-1:0]             pend_vec;
    logic                            mid_busy;
    logic                            indep;

    assign sl_valid = {s1_valid, s0_valid};
    assign sl_unit  = {s1_unit,  s0_unit};
    assign sl_mul   = {s1_mul,   s0_mul};
    assign sl_dst   = {s1_dst,   s0_dst};
    assign sl_src0  = {s1_src0,  s0_src0};
    assign sl_src1  = {s1_src1,  s0_src1};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        dic_slot_hazard #(
            .NUM_REGS (NUM_REGS),
            .REG_W    (REG_W)
        ) u_hazard (
            .valid     (sl_valid[s]),
            .unit      (sl_unit[s]),
            .dst       (sl_dst[s]),
            .src0      (sl_src0[s]),
            .src1      (sl_src1[s]),
            .pend_vec  (pend_vec),
            .unit_free (unit_free),
            .ready     (sl_ready[s])
        );
    end

    always_comb begin
        indep = (s1_src0 != s0_dst) && (s1_src1 != s0_dst) && (s1_dst != s0_dst)
             && (s0_src0 != s1_dst) && (s0_src1 != s1_dst);
        iss[0] = !rst && sl_ready[0];
        iss[1] = iss[0] && sl_ready[1] && (s1_unit != s0_unit) && indep && !mid_busy;
    end

    assign grant0 = iss[0];
    assign grant1 = iss[1];

    dic_unit_tracker #(
        .MUL_CYCLES (MUL_CYCLES),
        .ADD_CYCLES (ADD_CYCLES),
        .CNT_W      (CNT_W)
    ) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss),
        .iss_unit  (sl_unit),
        .iss_mul   (sl_mul),
        .unit_free (unit_free),
        .mid_busy  (mid_busy)
    );

    dic_scoreboard #(
        .NUM_REGS   (NUM_REGS),
        .REG_W      (REG_W),
        .PEND_W     (PEND_W),
        .MUL_CYCLES (MUL_CYCLES),
        .ADD_CYCLES (ADD_CYCLES),
        .WB_STAGES  (WB_STAGES)
    ) u_scoreboard (
        .clk       (clk),
        .rst       (rst),
        .set_valid (iss),
        .set_dst   (sl_dst),
        .set_mul   (sl_mul),
        .pend_vec  (pend_vec)
    );

    logic arith_mul_iss;
    logic arith_iss;
    logic any_mul_iss;

    always_comb begin
        arith_iss     = (grant0 && (s0_unit == UC_ARITH)) || (grant1 && (s1_unit == UC_ARITH));
        arith_mul_iss = (grant0 && s0_mul && (s0_unit == UC_ARITH))
                     || (grant1 && s1_mul && (s1_unit == UC_ARITH));
        any_mul_iss   = (grant0 && s0_mul) || (grant1 && s1_mul);
    end

    if (MUL_CYCLES >= 3) begin : g_mul_checks
        AST_MUL_HOLDS_UNIT: assert property (@(posedge clk) disable iff (rst)
            $past(arith_mul_iss) |-> !arith_iss); // R3
        AST_NO_MID_PAIR: assert property (@(posedge clk) disable iff (rst)
            $past(any_mul_iss) |-> !grant1); // R4
    end

    AST_RAW_WAIT: assert property (@(posedge clk) disable iff (rst)
        $past(grant0) |-> !(grant0 && ((s0_src0 == $past(s0_dst)) ||
                                       (s0_src1 == $past(s0_dst))))); // R7
endmodule

// File: tb/dual_issue_ctl_bench.sv
module dual_issue_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MULC = 4;
    localparam int ADDC = 2;
    localparam int WB   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s0_valid = 1'b0, s1_valid = 1'b0;
    logic [1:0] s0_unit = '0, s1_unit = '0;
    logic s0_mul = 1'b0, s1_mul = 1'b0;
    logic [3:0] s0_dst = '0, s0_src0 = '0, s0_src1 = '0;
    logic [3:0] s1_dst = '0, s1_src0 = '0, s1_src1 = '0;
    logic grant0, grant1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_ctl u_dual_issue_ctl (
        .clk(clk), .rst(rst),
        .s0_valid(s0_valid), .s0_unit(s0_unit), .s0_mul(s0_mul),
        .s0_dst(s0_dst), .s0_src0(s0_src0), .s0_src1(s0_src1),
        .s1_valid(s1_valid), .s1_unit(s1_unit), .s1_mul(s1_mul),
        .s1_dst(s1_dst), .s1_src0(s1_src0), .s1_src1(s1_src1),
        .grant0(grant0), .grant1(grant1)
    );

    task automatic check(input logic act, input int exp, input string tag, input string name);
        if (exp >= 0) begin
            checks++;
            if (act !== exp[0]) begin
                errors++;
                $display("FAIL %s %s: actual=%0d expected=%0d", tag, name, act, exp);
            end
        end
    endtask

    // Drive both slots at the falling edge, sample just after, commit at next rising edge.
    task automatic step(input int v0, u0, m0, d0, a0, b0,
                        input int v1, u1, m1, d1, a1, b1,
                        input int e0, e1, input string tag);
        @(negedge clk);
        s0_valid = v0[0]; s0_unit = 2'(u0); s0_mul = m0[0];
        s0_dst = 4'(d0); s0_src0 = 4'(a0); s0_src1 = 4'(b0);
        s1_valid = v1[0]; s1_unit = 2'(u1); s1_mul = m1[0];
        s1_dst = 4'(d1); s1_src0 = 4'(a1); s1_src1 = 4'(b1);
        #1;
        check(grant0, e0, tag, "grant0");
        check(grant1, e1, tag, "grant1");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s0_valid = 1'b0;
            s1_valid = 1'b0;
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        // R1: no grants during reset
        step(1,0,1,1,2,3, 1,1,0,4,5,6, 0,0, "R1 in reset");
        step(1,2,0,1,2,3, 1,1,0,4,5,6, 0,0, "R1 in reset");
        idle(1);
        rst = 1'b0;
        step(1,0,1,1,2,3, 1,1,0,4,5,6, 1,1, "R1 after reset");
        idle(1);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        // R1: register 1 was pending before reset, now must be clear
        step(1,1,0,7,1,3, 0,0,0,0,0,0, 1,0, "R1 pending cleared");
        idle(10);

        // R2 / R5: sweep of unit and latency combinations from idle state
        for (int u0 = 0; u0 < 3; u0++)
            for (int u1 = 0; u1 < 3; u1++)
                for (int m0 = 0; m0 < 2; m0++)
                    for (int m1 = 0; m1 < 2; m1++) begin
                        step(1,u0,m0,1,2,3, 1,u1,m1,4,5,6, 1, (u0 != u1) ? 1 : 0, "R5 sweep");
                        idle(MULC + WB + 2);
                    end

        // R2: reserved unit code never granted, in either slot
        step(1,3,0,1,2,3, 1,1,0,4,5,6, 0,0, "R2 reserved slot0");
        step(1,1,0,1,2,3, 1,3,0,4,5,6, 1,0, "R2 reserved slot1");
        idle(8);

        // R4: pairing window around a multiply
        step(1,0,1,1,2,3,  1,1,0,4,5,6,   1,1, "R4 first cycle");
        step(1,1,0,7,2,3,  1,2,0,10,5,6,  1,0, "R4 intermediate 1");
        step(1,1,0,13,2,3, 1,2,0,14,5,6,  1,0, "R4 intermediate 2");
        step(1,1,0,15,2,3, 1,2,0,0,5,6,   1,1, "R4 last cycle");
        idle(8);
        // R4: an add never closes the window
        step(1,0,0,1,2,3,  0,0,0,0,0,0,   1,0, "R4 add issue");
        step(1,1,0,4,2,3,  1,2,0,7,5,6,   1,1, "R4 after add");
        idle(8);

        // R3: back-to-back multiplies on the arithmetic unit
        step(1,0,1,1,2,3, 0,0,0,0,0,0, 1,0, "R3 first mul");
        step(1,0,1,4,2,3, 0,0,0,0,0,0, 0,0, "R3 held");
        step(1,0,1,4,2,3, 0,0,0,0,0,0, 0,0, "R3 held");
        step(1,0,1,4,2,3, 0,0,0,0,0,0, 1,0, "R3 last-cycle reuse");
        idle(8);
        step(1,0,0,1,2,3, 0,0,0,0,0,0, 1,0, "R3 add");
        step(1,0,0,4,2,3, 0,0,0,0,0,0, 1,0, "R3 add reuse next cycle");
        idle(8);

        // R7: pending register releases exactly at t+L+WB+1
        for (int m = 0; m < 2; m++)
            for (int pos = 0; pos < 3; pos++) begin
                int lat;
                int wait_c;
                lat = (m == 1) ? MULC : ADDC;
                wait_c = lat + WB + 1;
                step(1,0,m,9,2,3, 0,0,0,0,0,0, 1,0, "R7 producer");
                for (int k = 1; k <= wait_c; k++) begin
                    int d;
                    int a;
                    int b;
                    d = (pos == 2) ? 9 : 10;
                    a = (pos == 0) ? 9 : 2;
                    b = (pos == 1) ? 9 : 3;
                    step(1,1,0,d,a,b, 0,0,0,0,0,0, (k == wait_c) ? 1 : 0, 0, "R7 consumer");
                end
                idle(8);
            end

        // R6: independence between slots
        step(1,0,0,1,2,3, 1,1,0,4,1,6, 1,0, "R6 RAW src0");
        idle(8);
        step(1,0,0,1,2,3, 1,1,0,4,5,1, 1,0, "R6 RAW src1");
        idle(8);
        step(1,0,0,1,2,3, 1,1,0,1,5,6, 1,0, "R6 WAW");
        idle(8);
        step(1,0,0,1,2,3, 1,1,0,2,5,6, 1,0, "R6 WAR src0");
        idle(8);
        step(1,0,0,1,2,3, 1,1,0,3,5,6, 1,0, "R6 WAR src1");
        idle(8);
        step(1,0,0,1,2,3, 1,1,0,4,5,6, 1,1, "R6 independent");
        idle(8);

        // R8: in-order issue
        step(0,0,0,1,2,3, 1,1,0,4,5,6, 0,0, "R8 slot0 invalid");
        step(1,0,1,1,2,3, 0,0,0,0,0,0, 1,0, "R8 mul");
        step(1,0,0,7,2,3, 1,1,0,4,5,6, 0,0, "R8 slot0 blocked");
        idle(8);
        step(1,1,0,1,2,3, 0,1,0,4,5,6, 1,0, "R8 slot1 invalid");
        idle(8);

        report();
        $finish;
    end
endmodule